// File: doc/BRIEF.md
# Dual-Thread Partitioned Reorder Buffer

This block holds micro-ops for two hardware threads between dispatch and commit. Storage is divided into two equal, independent ring queues, one per thread. The allocator asks for a slot on behalf of a thread and receives the slot index for that thread. An execution unit later reports completion by thread and slot index, in any order it likes. The block retires completed work from the oldest end of each thread's queue, so each thread commits in its own program order. A thread whose oldest entry is still waiting never holds back the other thread.

Each cycle at most one entry retires. When both threads have a completed oldest entry, the thread that did not retire last goes first. A retiring store raises a drain request to the data cache in the same cycle as the commit. Every retirement also pulses a per-thread free strobe, so the allocator can reuse the slot.

Top module: `rob_dual_part`

## Requirements
- R1: Each thread owns PART_DEPTH slots (default 63, 126 in total). The slot index offered to a thread starts at 0 after reset, rises by one per accepted allocation, and wraps from PART_DEPTH-1 back to 0.
- R2: `alloc_gnt[t]` is high exactly when `alloc_req[t]` is high and thread t holds fewer than PART_DEPTH live entries. A refused request changes nothing.
- R3: Completions may arrive in any order. An entry retires only after it and every older entry of the same thread have completed, and each thread's entries retire in allocation order.
- R4: At most one entry retires per cycle, and all retirement outputs are registered. When the oldest entry of a thread is completed at clock edge m and that thread is chosen, `ret_valid` is high after edge m+1 and carries the thread and destination recorded at allocation.
- R5: A thread whose oldest entry has not completed does not delay retirement of the other thread.
- R6: When both oldest entries are complete, the thread other than the one that retired last is chosen. Thread 0 is preferred first after reset. When only one is complete, that thread retires.
- R7: When a store retires, `st_req_valid` is high in the same cycle as `ret_valid`, with the same thread in `st_req_tid` and the slot index in `st_req_idx`. A non-store retirement leaves `st_req_valid` low.
- R8: `free_pulse[t]` is high for exactly the cycles in which a thread-t entry is shown as retired. Bit t is one-hot with `ret_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 2 | Per-thread allocation request |
| alloc_dest | input | 2*DEST_W | Per-thread destination tag, thread t in bits [t*DEST_W +: DEST_W] |
| alloc_store | input | 2 | Per-thread flag marking the micro-op as a store |
| alloc_gnt | output | 2 | Per-thread allocation accepted |
| alloc_idx | output | 2*IDX_W | Per-thread slot index given to the next allocation |
| wb_valid | input | 1 | Completion report valid |
| wb_tid | input | 1 | Thread of the completed entry |
| wb_idx | input | IDX_W | Slot index of the completed entry |
| ret_valid | output | 1 | An entry commits this cycle |
| ret_tid | output | 1 | Thread of the committing entry |
| ret_dest | output | DEST_W | Destination tag of the committing entry |
| st_req_valid | output | 1 | Data-cache write request for a committing store |
| st_req_tid | output | 1 | Thread of the store being drained |
| st_req_idx | output | IDX_W | Slot index of the store being drained |
| free_pulse | output | 2 | Per-thread slot-released strobe |

## Verification
The bench targets completions that arrive younger-first. A design that retired on any completed entry, rather than only on the oldest, would commit out of order. It fills a small partition to the brim to test the full boundary: an off-by-one there either grants one slot too many or refuses the last slot. The bench also walks both ring pointers past the odd-sized wrap, where a power-of-two wrap would hand out an index that does not exist. It stalls one thread while the other drains, and then makes both heads ready together to expose a fixed-priority picker. A long mixed sweep of allocation, refusal and completion runs against an arithmetic model, which catches a drain request that fires for a non-store or a free strobe sent to the wrong thread.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int NTHR = 2;

  // Picks the thread to retire given which heads are ready and who went last.
  function automatic logic alt_choose(input logic [1:0] rdy, input logic last);
    if (rdy == 2'b11) return ~last;
    return rdy[1];
  endfunction
endpackage

// File: rtl/rob_partition.sv
module rob_partition #(
  parameter int DEPTH  = 63,
  parameter int DEST_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              alloc_store,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              pop,
  output logic              full,
  output logic [IDX_W-1:0]  tail_idx,
  output logic              head_rdy,
  output logic [IDX_W-1:0]  head_idx,
  output logic [DEST_W-1:0] head_dest,
  output logic              head_store
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [DEST_W:0]    pay_mem [DEPTH];
  logic [DEPTH-1:0]   done_q;
  logic [IDX_W-1:0]   head_q, tail_q;
  logic [CNT_W-1:0]   cnt_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // Payload storage: written once at allocation, no reset, RAM-friendly.
  always_ff @(posedge clk) begin
    if (alloc_en) pay_mem[tail_q] <= {alloc_store, alloc_dest};
  end

  // Completion flags: set by writeback, cleared when a slot is reissued.
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
    end else begin
      if (wb_en)    done_q[wb_idx] <= 1'b1;
      if (alloc_en) done_q[tail_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc_en) tail_q <= bump(tail_q);
      if (pop)      head_q <= bump(head_q);
      case ({alloc_en, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign tail_idx   = tail_q;
  assign head_idx   = head_q;
  assign head_rdy   = (cnt_q != '0) && done_q[head_q];
  assign {head_store, head_dest} = pay_mem[head_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) alloc_en |-> !full); // R2
  AST_POP_READY:   assert property (@(posedge clk) disable iff (rst) pop |-> head_rdy); // R3
  AST_WB_LIVE:     assert property (@(posedge clk) disable iff (rst) wb_en |-> cnt_q != '0); // R3
endmodule

// File: rtl/rob_retire_arb.sv
module rob_retire_arb import rob_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rdy,
  output logic       pick_vld,
  output logic       pick_tid
);
  logic last_q;

  assign pick_vld = |rdy;
  assign pick_tid = alt_choose(rdy, last_q);

  // Reset to thread 1 so thread 0 wins the first tie.
  always_ff @(posedge clk) begin
    if (rst)           last_q <= 1'b1;
    else if (pick_vld) last_q <= pick_tid;
  end

  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && rdy == 2'b11 && $past(pick_vld)) |-> pick_tid != $past(pick_tid)); // R6
endmodule

// File: rtl/rob_dual_part.sv
module rob_dual_part import rob_pkg::*; #(
  parameter int PART_DEPTH = 63,
  parameter int DEST_W     = 6,
  localparam int IDX_W     = $clog2(PART_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NTHR-1:0]        alloc_req,
  input  logic [NTHR*DEST_W-1:0] alloc_dest,
  input  logic [NTHR-1:0]        alloc_store,
  output logic [NTHR-1:0]        alloc_gnt,
  output logic [NTHR*IDX_W-1:0]  alloc_idx,
  input  logic                   wb_valid,
  input  logic                   wb_tid,
  input  logic [IDX_W-1:0]       wb_idx,
  output logic                   ret_valid,
  output logic                   ret_tid,
  output logic [DEST_W-1:0]      ret_dest,
  output logic                   st_req_valid,
  output logic                   st_req_tid,
  output logic [IDX_W-1:0]       st_req_idx,
  output logic [NTHR-1:0]        free_pulse
);
  logic [NTHR-1:0]   full_v, rdy_v, store_v, pop_v;
  logic [IDX_W-1:0]  tail_a [NTHR];
  logic [IDX_W-1:0]  hidx_a [NTHR];
  logic [DEST_W-1:0] hdst_a [NTHR];
  logic              pick_vld, pick_tid;

  for (genvar t = 0; t < NTHR; t++) begin : g_part
    localparam logic TID = 1'(t);

    assign alloc_gnt[t] = alloc_req[t] & ~full_v[t];
    assign alloc_idx[t*IDX_W +: IDX_W] = tail_a[t];
    assign pop_v[t] = pick_vld && (pick_tid == TID);

    rob_partition #(.DEPTH(PART_DEPTH), .DEST_W(DEST_W)) u_part (
      .clk         (clk),
      .rst         (rst),
      .alloc_en    (alloc_gnt[t]),
      .alloc_dest  (alloc_dest[t*DEST_W +: DEST_W]),
      .alloc_store (alloc_store[t]),
      .wb_en       (wb_valid && (wb_tid == TID)),
      .wb_idx      (wb_idx),
      .pop         (pop_v[t]),
      .full        (full_v[t]),
      .tail_idx    (tail_a[t]),
      .head_rdy    (rdy_v[t]),
      .head_idx    (hidx_a[t]),
      .head_dest   (hdst_a[t]),
      .head_store  (store_v[t])
    );
  end

  rob_retire_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .rdy      (rdy_v),
    .pick_vld (pick_vld),
    .pick_tid (pick_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid    <= 1'b0;
      ret_tid      <= 1'b0;
      ret_dest     <= '0;
      st_req_valid <= 1'b0;
      st_req_tid   <= 1'b0;
      st_req_idx   <= '0;
      free_pulse   <= '0;
    end else begin
      ret_valid    <= pick_vld;
      free_pulse   <= pop_v;
      st_req_valid <= pick_vld && store_v[pick_tid];
      if (pick_vld) begin
        ret_tid    <= pick_tid;
        ret_dest   <= hdst_a[pick_tid];
        st_req_tid <= pick_tid;
        st_req_idx <= hidx_a[pick_tid];
      end
    end
  end

  AST_ONE_RETIRE:     assert property (@(posedge clk) disable iff (rst) $onehot0(pop_v)); // R4
  AST_STORE_WITH_RET: assert property (@(posedge clk) disable iff (rst)
    st_req_valid |-> (ret_valid && st_req_tid == ret_tid)); // R7
  AST_FREE_MATCH:     assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> ($countones(free_pulse) == 1 && free_pulse[ret_tid])); // R8
  AST_FREE_QUIET:     assert property (@(posedge clk) disable iff (rst)
    !ret_valid |-> free_pulse == '0); // R8
endmodule

// File: tb/tb_rob_dual_part.sv
`timescale 1ns/1ps
module tb_rob_dual_part;
  localparam int D  = 5;
  localparam int DW = 4;
  localparam int IW = $clog2(D);
  localparam time CLK_P = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    alloc_req = '0;
  logic [2*DW-1:0] alloc_dest = '0;
  logic [1:0]    alloc_store = '0;
  logic [1:0]    alloc_gnt;
  logic [2*IW-1:0] alloc_idx;
  logic          wb_valid = 1'b0;
  logic          wb_tid = 1'b0;
  logic [IW-1:0] wb_idx = '0;
  logic          ret_valid, ret_tid, st_req_valid, st_req_tid;
  logic [DW-1:0] ret_dest;
  logic [IW-1:0] st_req_idx;
  logic [1:0]    free_pulse;

  rob_dual_part #(.PART_DEPTH(D), .DEST_W(DW)) dut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_dest(alloc_dest),
    .alloc_store(alloc_store), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
    .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_idx(wb_idx),
    .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_dest(ret_dest),
    .st_req_valid(st_req_valid), .st_req_tid(st_req_tid), .st_req_idx(st_req_idx),
    .free_pulse(free_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Arithmetic model of the requirements
  int  m_head [2];
  int  m_tail [2];
  int  m_cnt  [2];
  int  m_dest [2][D];
  bit  m_st   [2][D];
  bit  m_done [2][D];
  int  m_last;
  bit  e_rv, e_tid, e_st;
  int  e_dest, e_idx;
  bit [1:0] e_free;

  always @(posedge clk) begin : model
    bit r0, r1, pv, f0, f1;
    int pk;
    if (rst) begin
      for (int t = 0; t < 2; t++) begin
        m_head[t] = 0; m_tail[t] = 0; m_cnt[t] = 0;
        for (int i = 0; i < D; i++) m_done[t][i] = 1'b0;
      end
      m_last = 1; e_rv = 0; e_st = 0; e_free = 0; e_tid = 0; e_dest = 0; e_idx = 0;
    end else begin
      r0 = (m_cnt[0] > 0) && m_done[0][m_head[0]];
      r1 = (m_cnt[1] > 0) && m_done[1][m_head[1]];
      f0 = (m_cnt[0] == D);
      f1 = (m_cnt[1] == D);
      pv = r0 | r1;
      pk = (r0 && r1) ? 1 - m_last : (r1 ? 1 : 0);
      e_rv = pv; e_free = 2'b00; e_st = 1'b0;
      if (pv) begin
        e_tid = pk[0];
        e_dest = m_dest[pk][m_head[pk]];
        e_st = m_st[pk][m_head[pk]];
        e_idx = m_head[pk];
        e_free[pk] = 1'b1;
        m_head[pk] = (m_head[pk] + 1) % D;
        m_cnt[pk]--;
        m_last = pk;
      end
      if (wb_valid) m_done[wb_tid][wb_idx] = 1'b1;
      for (int t = 0; t < 2; t++) begin
        if (alloc_req[t] && !((t == 0) ? f0 : f1)) begin
          m_dest[t][m_tail[t]] = int'(alloc_dest[t*DW +: DW]);
          m_st[t][m_tail[t]]   = alloc_store[t];
          m_done[t][m_tail[t]] = 1'b0;
          m_tail[t] = (m_tail[t] + 1) % D;
          m_cnt[t]++;
        end
      end
    end
  end

  // Cycle monitor, sampled 4 ns after each rising edge
  always @(posedge clk) begin : monitor
    #4ns;
    if (!rst) begin
      chk(ret_valid == e_rv, "R4", "ret_valid", int'(ret_valid), int'(e_rv));
      chk(free_pulse == e_free, "R8", "free_pulse", int'(free_pulse), int'(e_free));
      chk(st_req_valid == (e_rv && e_st), "R7", "st_req_valid", int'(st_req_valid), int'(e_rv && e_st));
      if (e_rv) begin
        chk(ret_tid == e_tid, "R6", "ret_tid", int'(ret_tid), int'(e_tid));
        chk(int'(ret_dest) == e_dest, "R3", "ret_dest", int'(ret_dest), e_dest);
        if (e_st) chk(int'(st_req_idx) == e_idx && st_req_tid == e_tid, "R7", "st_req_idx",
                      int'(st_req_idx), e_idx);
      end
      for (int t = 0; t < 2; t++) begin
        chk(alloc_gnt[t] == (alloc_req[t] && m_cnt[t] < D), "R2", "alloc_gnt",
            int'(alloc_gnt[t]), int'(alloc_req[t] && m_cnt[t] < D));
        chk(int'(alloc_idx[t*IW +: IW]) == m_tail[t], "R1", "alloc_idx",
            int'(alloc_idx[t*IW +: IW]), m_tail[t]);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_wb(input bit v, input bit t, input int i);
    wb_valid = v; wb_tid = t; wb_idx = IW'(i);
  endtask

  task automatic chk_ret(input string tag, input bit v, input bit t, input int dst);
    chk(ret_valid == v, tag, "ret_valid", int'(ret_valid), int'(v));
    if (v) begin
      chk(ret_tid == t, tag, "ret_tid", int'(ret_tid), int'(t));
      chk(int'(ret_dest) == dst, tag, "ret_dest", int'(ret_dest), dst);
    end
  endtask

  // Returns a slot of thread t that is live and not yet completed, or -1.
  function automatic int pick_open(input int t, input int ofs);
    for (int k = 0; k < m_cnt[t]; k++) begin
      int s = (m_head[t] + (k + ofs) % m_cnt[t]) % D;
      if (!m_done[t][s]) return s;
    end
    return -1;
  endfunction

  initial begin : watchdog
    #(CLK_P * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) step();
    // Reset state
    chk(ret_valid == 1'b0 && free_pulse == 2'b00 && st_req_valid == 1'b0, "R4", "reset outputs",
        int'({ret_valid, free_pulse, st_req_valid}), 0);
    chk(alloc_idx == '0, "R1", "reset alloc_idx", int'(alloc_idx), 0);
    rst = 1'b0;
    step();

    // Fill thread 0, sixth request refused (R2), indices 0..4 (R1)
    for (int i = 0; i < 6; i++) begin
      alloc_req = 2'b01;
      alloc_dest[DW-1:0] = DW'(i + 1);
      alloc_store = {1'b0, (i == 2)};
      #1ns;
      chk(alloc_gnt[0] == (i < 5), "R2", "gnt while filling", int'(alloc_gnt[0]), int'(i < 5));
      if (i < 5) chk(int'(alloc_idx[IW-1:0]) == i, "R1", "fill index", int'(alloc_idx[IW-1:0]), i);
      step();
    end
    alloc_req = 2'b00; alloc_store = 2'b00;

    // Younger-first completions do not retire (R3)
    set_wb(1, 0, 3); step();
    set_wb(1, 0, 1); step();
    set_wb(0, 0, 0); step();
    chk_ret("R3", 0, 0, 0); step();
    chk_ret("R3", 0, 0, 0);
    set_wb(1, 0, 0); step();
    set_wb(0, 0, 0); step();
    chk_ret("R4", 1, 0, 1);
    chk(free_pulse == 2'b01, "R8", "free t0", int'(free_pulse), 1);
    step(); chk_ret("R3", 1, 0, 2);
    step(); chk_ret("R3", 0, 0, 0);

    // Thread 1 stalled, thread 0 proceeds (R5); store drain (R7)
    alloc_req = 2'b10; alloc_dest[2*DW-1:DW] = DW'(9);
    set_wb(1, 0, 2); step();
    alloc_dest[2*DW-1:DW] = DW'(10); set_wb(0, 0, 0); step();
    alloc_req = 2'b00;
    chk_ret("R5", 1, 0, 3);
    chk(st_req_valid == 1'b1 && int'(st_req_idx) == 2, "R7", "store drain", int'(st_req_idx), 2);
    step(); chk_ret("R5", 1, 0, 4);
    chk(st_req_valid == 1'b0, "R7", "no drain for non-store", int'(st_req_valid), 0);
    step(); chk_ret("R5", 0, 0, 0);

    // Wrap of thread 0 index (R1), then tie alternation (R6)
    chk(int'(alloc_idx[IW-1:0]) == 0, "R1", "wrap index", int'(alloc_idx[IW-1:0]), 0);
    alloc_req = 2'b01; alloc_dest[DW-1:0] = DW'(11); step();
    alloc_dest[DW-1:0] = DW'(12); step();
    alloc_req = 2'b00;
    set_wb(1, 0, 0); step();
    set_wb(1, 0, 1); step();
    set_wb(1, 1, 1); step();
    set_wb(1, 0, 4); step();
    set_wb(1, 1, 0); step();
    set_wb(0, 0, 0);
    chk_ret("R6", 1, 0, 5); step();
    chk_ret("R6", 1, 1, 9); step();
    chk_ret("R6", 1, 0, 11); step();
    chk_ret("R6", 1, 1, 10); step();
    chk_ret("R6", 1, 0, 12); step();
    chk_ret("R6", 0, 0, 0);

    // Mixed sweep against the model
    for (int c = 0; c < 4000; c++) begin
      int t, s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      alloc_req = lfsr[1:0] & {lfsr[8] | lfsr[9], lfsr[10] | lfsr[11]};
      alloc_dest = lfsr[15:8];
      alloc_store = lfsr[5:4];
      t = int'(lfsr[6]);
      s = pick_open(t, int'(lfsr[14:12]));
      if (s < 0) begin t = 1 - t; s = pick_open(t, 0); end
      if (s >= 0 && lfsr[7] | lfsr[3]) set_wb(1, t[0], s);
      else set_wb(0, 0, 0);
      step();
    end

    // Drain everything
    alloc_req = 2'b00;
    for (int c = 0; c < 300; c++) begin
      int s0, s1;
      s0 = pick_open(0, 0);
      s1 = pick_open(1, 0);
      if (s0 >= 0) set_wb(1, 0, s0);
      else if (s1 >= 0) set_wb(1, 1, s1);
      else set_wb(0, 0, 0);
      step();
    end
    alloc_req = 2'b11; #1ns;
    chk(alloc_gnt == 2'b11, "R2", "both empty after drain", int'(alloc_gnt), 3);
    chk(m_cnt[0] == 0 && m_cnt[1] == 0, "R3", "model drained", m_cnt[0] + m_cnt[1], 0);
    step();
    alloc_req = 2'b00;
    repeat (4) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule